// File: doc/BRIEF.md
# DMA Transfer Count Register Bank

This block keeps the remaining transfer count for each of a set of DMA channels (two by default). Each channel has a 10-bit down-counter. Software reaches it as a 16-bit register and can write the low byte, the high byte or the whole halfword. A transfer engine drives a per-channel busy flag and a strobe that marks each completed transfer. Each strobe taken while the channel is busy lowers that channel's count by one.

Software loads the count before it starts a channel. A loaded value of zero asks for 1024 transfers, because the first decrement wraps the counter to 3FFH. While a transfer runs, reading the register shows how many transfers remain. When the last pending transfer completes, the block raises a one-cycle terminal-count pulse for that channel. A write to a busy channel is dropped, so software cannot disturb a run in progress.

Top module: `xfer_count_bank`

## Requirements
- R1: After reset every channel's count reads 0000H and every terminal-count pulse is low.
- R2: rd_data shows the count of the channel chosen by reg_sel (0 or 1) in bits 9:0. Bits 15:10 always read zero.
- R3: A write with byte_en = 2'b11 to an idle channel loads wr_data[9:0] on the clock edge. wr_data[15:10] is discarded.
- R4: A write with only byte_en[0] set replaces count bits 7:0 with wr_data[7:0] and keeps bits 9:8. A write with only byte_en[1] set replaces count bits 9:8 with wr_data[9:8] and keeps bits 7:0.
- R5: When busy and xfer_done are both high for a channel, its count drops by one on the edge, modulo 1024. So 000H becomes 3FFH.
- R6: A write to a channel whose busy flag is high leaves its count unchanged, and the decrement takes effect as normal.
- R7: tc_pulse for a channel is high for exactly the one cycle after a decrement from 001H to 000H. A wrap from 000H raises no pulse.
- R8: The channels are independent. Writes, decrements and pulses on one channel never change another, including when both channels are active in the same cycle.
- R9: xfer_done has no effect on a channel whose busy flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | Channel selected for read and write |
| wr_en | input | 1 | Write strobe |
| byte_en | input | 2 | Byte-lane enables (bit 0 = bits 7:0, bit 1 = bits 15:8) |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Count of the selected channel, zero-extended |
| busy | input | 2 | Per-channel transfer-active flags from the engine |
| xfer_done | input | 2 | Per-channel completed-transfer strobes |
| tc_pulse | output | 2 | Per-channel one-cycle terminal-count pulses |

## Verification
The bench loads zero and counts down all 1024 transfers. A design that treated zero as empty would stop at once or pulse early, and one without the wrap would stick at zero. It writes single byte lanes and writes with ones in the upper bits: a lane decoded wrongly corrupts the bits that should be kept, and a design that stored the upper bits would read back non-zero high bits. It writes to busy channels and strobes xfer_done on idle channels, where a missing qualifier shows up as a count that changes. A long random run drives both channels at once, so a shared or crossed control path makes the two counts drift apart from the model.

// File: rtl/xcb_pkg.sv
package xcb_pkg;
   localparam int XCB_LANE_W = 8;
   function automatic int xcb_lanes(input int reg_w);
      return reg_w / XCB_LANE_W;
   endfunction
endpackage

// File: rtl/xcb_channel.sv
module xcb_channel
   import xcb_pkg::*;
#(
   parameter int CNT_W = 10,
   parameter int LANES = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_hit,
   input  logic [LANES-1:0] byte_en,
   input  logic [CNT_W-1:0] wr_bits,
   input  logic             busy,
   input  logic             xfer_done,
   output logic [CNT_W-1:0] cnt,
   output logic             tc
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] wmask;
   logic             dec;
   logic             load;

   for (genvar i = 0; i < CNT_W; i++) begin : g_mask
      assign wmask[i] = byte_en[i / XCB_LANE_W];
   end

   assign dec  = busy & xfer_done;
   assign load = wr_hit & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         tc  <= 1'b0;
      end else begin
         tc <= dec && (cnt == ONE);
         if (dec)
            cnt <= cnt - ONE;
         else if (load)
            cnt <= (cnt & ~wmask) | (wr_bits & wmask);
      end
   end

   // R5: each qualified strobe takes exactly one off, modulo the counter width
   a_r5_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && xfer_done) |=> (cnt == $past(cnt) - ONE));
   // R6 / R9: a busy channel without a strobe holds its count whatever software writes
   a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !xfer_done) |=> $stable(cnt));
   // R9: an idle channel with no write holds its count
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !wr_hit) |=> $stable(cnt));
   // R3: full halfword write to an idle channel loads the data
   a_r3_full_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !busy && (&byte_en)) |=> (cnt == $past(wr_bits)));
   // R7: a pulse follows only a strobe taken at count one
   a_r7_tc_source: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> (cnt == '0 && $past(busy && xfer_done) && $past(cnt) == ONE));
endmodule

// File: rtl/xcb_rdmux.sv
module xcb_rdmux #(
   parameter int NUM_CH = 2,
   parameter int CNT_W  = 10,
   parameter int REG_W  = 16,
   parameter int SEL_W  = 1
)(
   input  logic [SEL_W-1:0]             sel,
   input  logic [NUM_CH-1:0][CNT_W-1:0] cnts,
   output logic [REG_W-1:0]             rd_data
);
   always_comb begin
      rd_data = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (sel == SEL_W'(c))
            rd_data = REG_W'(cnts[c]);
      end
   end

   // R2: upper bits never read as one
   always_comb begin
      a_r2_upper_zero: assert (rd_data[REG_W-1:CNT_W] == '0);
   end
endmodule

// File: rtl/xfer_count_bank.sv
module xfer_count_bank
   import xcb_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int CNT_W  = 10,
   parameter int REG_W  = 16,
   localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int LANES = REG_W / 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic              wr_en,
   input  logic [LANES-1:0]  byte_en,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   input  logic [NUM_CH-1:0] busy,
   input  logic [NUM_CH-1:0] xfer_done,
   output logic [NUM_CH-1:0] tc_pulse
);
   if (REG_W % XCB_LANE_W != 0) begin : g_bad_reg
      $error("REG_W must be a whole number of bytes");
   end
   if (CNT_W >= REG_W || CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1 and below REG_W");
   end
   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end

   logic [NUM_CH-1:0][CNT_W-1:0] cnts;
   logic                         unused_hi;

   assign unused_hi = ^wr_data[REG_W-1:CNT_W];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit;
      assign hit = wr_en && (reg_sel == SEL_W'(c));
      xcb_channel #(.CNT_W(CNT_W), .LANES(LANES)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_hit    (hit),
         .byte_en   (byte_en),
         .wr_bits   (wr_data[CNT_W-1:0]),
         .busy      (busy[c]),
         .xfer_done (xfer_done[c]),
         .cnt       (cnts[c]),
         .tc        (tc_pulse[c])
      );
   end

   xcb_rdmux #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .REG_W(REG_W), .SEL_W(SEL_W)) u_rd (
      .sel     (reg_sel),
      .cnts    (cnts),
      .rd_data (rd_data)
   );

   // R7: a pulse never lasts two cycles on any channel
   a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_pulse != '0) |=> ((tc_pulse & $past(tc_pulse)) == '0));
endmodule

// File: tb/xfer_count_bank_test.sv
`timescale 1ns/1ps
module xfer_count_bank_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_sel = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  byte_en = 2'b00;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic [1:0]  busy = 2'b00;
   logic [1:0]  xfer_done = 2'b00;
   logic [1:0]  tc_pulse;

   int n_chk = 0;
   int n_bad = 0;
   logic [9:0] m_cnt [2];
   logic [1:0] m_tc;

   always #10 clk = ~clk;

   xfer_count_bank uut (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
      .byte_en(byte_en), .wr_data(wr_data), .rd_data(rd_data),
      .busy(busy), .xfer_done(xfer_done), .tc_pulse(tc_pulse)
   );

   function automatic logic [9:0] f_next(input logic [9:0] cur, input logic b,
                                         input logic d, input logic hit,
                                         input logic [1:0] be, input logic [15:0] wd);
      logic [9:0] r;
      r = cur;
      if (b && d) r = cur - 10'd1;
      else if (hit && !b) begin
         if (be[0]) r[7:0] = wd[7:0];
         if (be[1]) r[9:8] = wd[9:8];
      end
      return r;
   endfunction

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic look(input string tag);
      chk(tag, {14'd0, tc_pulse}, {14'd0, m_tc});
      for (int c = 0; c < 2; c++) begin
         reg_sel = c[0];
         #1;
         chk(tag, rd_data, {6'd0, m_cnt[c]});
      end
   endtask

   // called just after a falling edge; drives one cycle and checks after the next fall
   task automatic step(input string tag, input logic s, input logic we,
                       input logic [1:0] be, input logic [15:0] wd,
                       input logic [1:0] b, input logic [1:0] d);
      reg_sel = s; wr_en = we; byte_en = be; wr_data = wd; busy = b; xfer_done = d;
      @(posedge clk);
      for (int c = 0; c < 2; c++) begin
         m_tc[c] = b[c] && d[c] && (m_cnt[c] == 10'd1);
         m_cnt[c] = f_next(m_cnt[c], b[c], d[c], we && (s == c[0]), be, wd);
      end
      @(negedge clk);
      wr_en = 1'b0; xfer_done = 2'b00; busy = 2'b00;
      look(tag);
   endtask

   initial begin
      #(20ns * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'd12345;
      void'($urandom(seed));
      m_cnt[0] = '0; m_cnt[1] = '0; m_tc = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      look("R1 reset");
      // R3: halfword load with junk in the upper bits, R2 upper reads zero
      step("R3 full load", 1'b0, 1'b1, 2'b11, 16'hFFFF, 2'b00, 2'b00);
      step("R2 R3 load ch1", 1'b1, 1'b1, 2'b11, 16'hFC05, 2'b00, 2'b00);
      // R4: byte lanes
      step("R4 low lane", 1'b0, 1'b1, 2'b01, 16'hFF12, 2'b00, 2'b00);
      step("R4 high lane", 1'b1, 1'b1, 2'b10, 16'h0233, 2'b00, 2'b00);
      // R9: strobe on idle channel
      step("R9 idle strobe", 1'b0, 1'b0, 2'b00, 16'h0, 2'b00, 2'b11);
      // R6: write to busy channel blocked, decrement wins
      step("R6 busy write", 1'b0, 1'b1, 2'b11, 16'h0001, 2'b01, 2'b00);
      step("R6 write+dec", 1'b0, 1'b1, 2'b11, 16'h0001, 2'b01, 2'b01);
      // R7: last transfer pulse, R8 other channel untouched
      step("R7 load one", 1'b1, 1'b1, 2'b11, 16'h0001, 2'b00, 2'b00);
      step("R7 last xfer", 1'b1, 1'b0, 2'b00, 16'h0, 2'b10, 2'b10);
      step("R7 pulse gone", 1'b1, 1'b0, 2'b00, 16'h0, 2'b10, 2'b00);
      // R5: 1024 transfers from a loaded zero on channel 0, channel 1 busy idle
      step("R5 load zero", 1'b0, 1'b1, 2'b11, 16'h0000, 2'b00, 2'b00);
      for (int k = 0; k < 1024; k++)
         step("R5 R7 count 1024", 1'b1, 1'b1, 2'b11, 16'h0155, 2'b01, 2'b01);
      // R8: random traffic on both channels
      for (int k = 0; k < 3000; k++) begin
         logic [15:0] wd;
         logic [1:0] b, d, be;
         logic s, we;
         wd = 16'($urandom);
         if ($urandom_range(0, 3) == 0) wd[9:0] = 10'($urandom_range(0, 3));
         b = 2'($urandom); d = 2'($urandom);
         be = 2'($urandom); s = 1'($urandom);
         we = ($urandom_range(0, 2) == 0);
         step("R8 random", s, we, be, wd, b, d);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule